// File: doc/BRIEF.md
# Carry-Select Adder for a Late Narrow Operand

This block adds a wide unsigned operand, which settles early in the cycle, to a narrow unsigned operand, which settles late. The result is as wide as the wide operand, and any carry out of the top bit is dropped. The sum is split at bit K, where K is the narrow operand's width. A K-bit adder combines the narrow operand with the low K bits of the wide operand and produces a carry.

The upper W-K bits of the sum depend only on the wide operand, so two candidates are built from it ahead of time: the plain upper bits and the upper bits plus one. The carry from the low stage then picks one of them through a single 2:1 multiplexer. The late operand passes through only a short adder and one mux level, and the long carry chain works on the early operand. The incrementer output and the mux output are separate named signals, so later optimisation does not fold them back into one long adder fed by the late carry.

The block is purely combinational. W and K are fixed when the design is elaborated. Elaboration stops on a K or W-K outside the supported range.

Top module: `narrow_late_csa`

## Requirements
- R1: `sum_out` equals (`a_in` + `b_in`) modulo 2^W for every pair of unsigned inputs.
- R2: Bits [K-1:0] of `sum_out` equal the low K bits of (`a_in[K-1:0]` + `b_in`).
- R3: When `a_in[K-1:0]` + `b_in` is below 2^K (no low carry), `sum_out[W-1:K]` equals `a_in[W-1:K]` unchanged.
- R4: When `a_in[K-1:0]` + `b_in` is 2^K or more (low carry), `sum_out[W-1:K]` equals `a_in[W-1:K]` + 1 modulo 2^(W-K). All-ones upper bits wrap to zero.
- R5: The carry out of bit W-1 is discarded. With `a_in` all ones and `b_in` = 1, `sum_out` is zero.
- R6: With `b_in` = 0, `sum_out` equals `a_in`.
- R7: The limit configuration K = 16 with W-K = 8 is accepted and obeys R1. Elaboration stops if K < 1, K > 16 or W-K < 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W | Wide, early-arriving unsigned operand |
| b_in | input | K | Narrow, late-arriving unsigned operand |
| sum_out | output | W | Sum modulo 2^W |

## Verification
The assertions check the inputs only once both are fully known. They assume nothing about operand ranges: every bit pattern of `a_in` and `b_in` is a legal, unsigned input. The bench drives only fully defined values, taken from a seeded `$urandom` stream and from directed patterns. The directed patterns cover all-ones upper bits with a carry, a zero narrow operand, a maximal narrow operand that forces a carry, and a full wrap of the result. The bench checks three instances: 32/5, 64/6, and the limit configuration 24/16.

// File: rtl/narrow_late_csa.sv
module narrow_late_csa #(
  parameter int W = 32,
  parameter int K = 5
) (
  input  logic [W-1:0] a_in,
  input  logic [K-1:0] b_in,
  output logic [W-1:0] sum_out
);

  localparam int MAX_NARROW = 16;
  localparam int MIN_UPPER  = 8;
  localparam int HI         = W - K;

  if (K < 1 || K > MAX_NARROW || HI < MIN_UPPER) begin : g_bad_cfg
    $error("narrow_late_csa: unsupported W/K combination");
  end

  logic [K:0]    lo_sum;
  logic          lo_carry;
  logic [HI-1:0] hi_plain;
  logic [HI-1:0] hi_inc;
  logic [HI-1:0] hi_pick;

  assign lo_sum   = {1'b0, a_in[K-1:0]} + {1'b0, b_in};
  assign lo_carry = lo_sum[K];

  assign hi_plain = a_in[W-1:K];
  assign hi_inc   = hi_plain + HI'(1);
  assign hi_pick  = lo_carry ? hi_inc : hi_plain;

  assign sum_out  = {hi_pick, lo_sum[K-1:0]};

  always_comb begin
    if (!$isunknown({a_in, b_in})) begin
      AST_SUM_MATCH: assert (sum_out == a_in + W'(b_in)); // R1
      AST_LOW_BITS: assert (sum_out[K-1:0] == K'(a_in[K-1:0] + b_in)); // R2
      if (!lo_carry) begin
        AST_HI_PLAIN: assert (sum_out[W-1:K] == a_in[W-1:K]); // R3
      end else begin
        AST_HI_INC: assert (sum_out[W-1:K] == HI'(a_in[W-1:K] + HI'(1))); // R4
      end
      AST_ZERO_NARROW: assert (b_in != '0 || sum_out == a_in); // R6
      AST_WRAP: assert (!(&a_in && b_in == K'(1)) || sum_out == '0); // R5
    end
  end

endmodule

// File: tb/test_narrow_late_csa.sv
module test_narrow_late_csa;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] a32;
  logic [4:0]  b32;
  logic [31:0] s32;
  logic [63:0] a64;
  logic [5:0]  b64;
  logic [63:0] s64;
  logic [23:0] a24;
  logic [15:0] b24;
  logic [23:0] s24;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  narrow_late_csa #(.W(32), .K(5)) i_narrow_late_csa (
    .a_in(a32), .b_in(b32), .sum_out(s32));
  narrow_late_csa #(.W(64), .K(6)) i_narrow_late_csa_w64 (
    .a_in(a64), .b_in(b64), .sum_out(s64));
  narrow_late_csa #(.W(24), .K(16)) i_narrow_late_csa_k16 (
    .a_in(a24), .b_in(b24), .sum_out(s24));

  function automatic logic [31:0] ref32(logic [31:0] a, logic [4:0] b);
    logic [32:0] t = {1'b0, a} + {28'd0, b};
    return t[31:0];
  endfunction

  function automatic logic [63:0] ref64(logic [63:0] a, logic [5:0] b);
    logic [64:0] t = {1'b0, a} + {59'd0, b};
    return t[63:0];
  endfunction

  function automatic logic [23:0] ref24(logic [23:0] a, logic [15:0] b);
    logic [24:0] t = {1'b0, a} + {9'd0, b};
    return t[23:0];
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] x32, input logic [4:0] y32,
                       input logic [63:0] x64, input logic [5:0] y64,
                       input logic [23:0] x24, input logic [15:0] y24);
    @(posedge clk);
    a32 = x32; b32 = y32;
    a64 = x64; b64 = y64;
    a24 = x24; b24 = y24;
    @(negedge clk);
  endtask

  task automatic full_check(input string tag);
    chk({tag, " R1 w32"}, 64'(s32), 64'(ref32(a32, b32)));
    chk({tag, " R1 w64"}, s64, ref64(a64, b64));
    chk({tag, " R7 w24k16"}, 64'(s24), 64'(ref24(a24, b24)));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));

    apply('0, '0, '0, '0, '0, '0);
    full_check("zero inputs");

    // R6: zero narrow operand passes the wide operand through
    apply(32'hDEAD_BEEF, 5'd0, 64'h0123_4567_89AB_CDEF, 6'd0, 24'hA5C3F1, 16'd0);
    chk("R6 w32", 64'(s32), 64'h0000_0000_DEAD_BEEF);
    chk("R6 w64", s64, 64'h0123_4567_89AB_CDEF);
    chk("r6_ w24", 64'(s24), 64'h0000_0000_00A5_C3F1);

    // R5: all ones plus one wraps to zero
    apply('1, 5'd1, '1, 6'd1, '1, 16'd1);
    chk("R5 w32", 64'(s32), 64'd0);
    chk("R5 w64", s64, 64'd0);
    chk("R5 w24", 64'(s24), 64'd0);

    // R4: all-ones upper bits with a low carry wrap to zero
    apply(32'hFFFF_FFE1, 5'd31, 64'hFFFF_FFFF_FFFF_FFC1, 6'd63, 24'hFF8001, 16'hFFFF);
    chk("R4 w32 upper", 64'(s32[31:5]), 64'd0);
    chk("R2 w32 low", 64'(s32[4:0]), 64'd0);
    chk("R4 w64 upper", 64'(s64[63:6]), 64'd0);
    chk("R2 w64 low", 64'(s64[5:0]), 64'd0);
    chk("R4 w24 upper", 64'(s24[23:16]), 64'd0);
    chk("R2 w24 low", 64'(s24[15:0]), 64'h8000);

    // R4: maximal narrow operand forces a carry on a mid-range upper value
    apply(32'h1234_5661, 5'd31, 64'h0000_0001_0000_0041, 6'd63, 24'h7F0001, 16'hFFFF);
    chk("R4 w32 max b", 64'(s32), 64'h0000_0000_1234_5680);
    chk("R4 w64 max b", s64, 64'h0000_0001_0000_0080);
    chk("R4 w24 max b", 64'(s24), 64'h0000_0000_0080_0000);

    // R3: no low carry leaves the upper bits untouched
    apply(32'hFFFF_FFE0, 5'd31, 64'hFFFF_FFFF_FFFF_FFC0, 6'd63, 24'hFF0000, 16'hFFFF);
    chk("R3 w32", 64'(s32), 64'h0000_0000_FFFF_FFFF);
    chk("R3 w64", s64, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R3 w24", 64'(s24), 64'h0000_0000_00FF_FFFF);

    // R1/R2/R3/R4: random vectors
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ra;
      logic [63:0] rw;
      logic [31:0] rb;
      logic        c32;
      ra = $urandom;
      rw = {$urandom, $urandom};
      rb = $urandom;
      if (n % 7 == 0) ra[31:5] = '1;
      if (n % 11 == 0) rw[63:6] = '1;
      apply(ra, rb[4:0], rw, rb[10:5], ra[23:0], rb[31:16]);
      full_check("random");
      c32 = ({1'b0, a32[4:0]} + {1'b0, b32}) > 6'd31;
      if (c32)
        chk("R4 random upper", 64'(s32[31:5]), 64'(27'(a32[31:5] + 27'd1)));
      else
        chk("R3 random upper", 64'(s32[31:5]), 64'(a32[31:5]));
      chk("R2 random low", 64'(s32[4:0]), 64'(5'(a32[4:0] + b32)));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule